// File: doc/BRIEF.md
# CAN Frame Time Stamp Unit

This block keeps a free-running 16-bit time base that advances once per CAN bit time. At the end of every valid frame it can copy that time base into the stamp slot of the message buffer that was active for the frame. The buffer may be a transmit buffer or a receive buffer. The frame engine supplies the bit-time tick, the end-of-frame strobe and the index of the active buffer. The control logic supplies the initialization-mode flag and the stamping enable.

The host reads each stored stamp one byte at a time through a combinational read port, choosing the buffer and either the upper or the lower byte. The lowest `NUM_TX` buffer indices are transmit buffers. A transmit buffer's stamp is visible only while that buffer's empty flag is set. The time base wraps silently, and there is no overflow output. Stamp storage has no reset value, so a slot's contents are undefined until its first capture.

Top module: `can_tstamp_unit`

## Requirements
- R1: With `ts_en` high, a cycle with `eof_valid` high stores the current time base into slot `act_idx`. The stored value can be read from the next cycle on.
- R2: The time base rises by exactly one in each cycle where `bit_tick` is high and `init_mode` is low. In every other cycle outside initialization mode it keeps its value.
- R3: The time base wraps from 16'hFFFF to 16'h0000 with no other visible effect.
- R4: While `init_mode` is high the time base is forced to zero, and it is also zero after reset.
- R5: With `ts_en` low, `eof_valid` writes nothing, and every stored stamp keeps its value.
- R6: When `eof_valid` and `bit_tick` are high in the same cycle, the stored value is the time base before that cycle's increment.
- R7: `rd_data` shows bits 15:8 of slot `rd_idx` when `rd_hi` is 1, and bits 7:0 of that slot when `rd_hi` is 0.
- R8: For a transmit slot (index below `NUM_TX`), `rd_data` is 0 while bit `tx_empty[rd_idx]` is 0. Receive slots ignore `tx_empty`.
- R9: An `act_idx` of `NUM_BUF` or above writes no slot. An `rd_idx` of `NUM_BUF` or above reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low reset of the time base |
| bit_tick | input | 1 | One pulse per CAN bit time |
| init_mode | input | 1 | Initialization mode; holds the time base at zero |
| ts_en | input | 1 | Enables stamping at end of frame |
| eof_valid | input | 1 | End of a valid frame, one cycle |
| act_idx | input | IDX_W (3) | Buffer active for the finishing frame |
| tx_empty | input | NUM_TX (3) | Empty flags of the transmit buffers |
| rd_idx | input | IDX_W (3) | Slot selected for reading |
| rd_hi | input | 1 | 1 selects the upper byte, 0 the lower byte |
| rd_data | output | BYTE_W (8) | Selected stamp byte |

## Verification
The time base cannot be seen directly. A miscount, a missed clear or a lost increment therefore shows up only in the next stamp captured after the fault, and it stays in every later stamp until the next initialization. A capture into the wrong slot, or a capture taken after the increment, shows on the first read of the affected slot, one cycle after the strobe. A read-path fault, such as swapped bytes, a missing transmit gate or an out-of-range slot that is not blanked, shows at once on the combinational read port.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
   localparam int unsigned HOST_BYTE_W = 8;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/tstamp_counter.sv
module tstamp_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic             init_mode,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         count <= '0;
      else if (init_mode) count <= '0;
      else if (bit_tick)  count <= count + ONE;
   end

   assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_mode && bit_tick) |=> (count == CNT_W'($past(count) + ONE)));
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_mode && !bit_tick) |=> $stable(count));
   assert_init_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      init_mode |=> (count == '0));
endmodule

// File: rtl/tstamp_bank.sv
module tstamp_bank #(
   parameter int unsigned NUM_BUF = 5,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned IDX_W   = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cap_en,
   input  logic [IDX_W-1:0]                cap_idx,
   input  logic [CNT_W-1:0]                count,
   output logic [NUM_BUF-1:0][CNT_W-1:0]   stamps
);
   for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot
      logic hit;
      assign hit = cap_en && (cap_idx == IDX_W'(i));

      // Stamp slots carry no reset: contents are undefined until first capture.
      always_ff @(posedge clk) begin
         if (hit) stamps[i] <= count;
      end

      assert_slot_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_en && cap_idx == IDX_W'(i)) |=> (stamps[i] == $past(count)));
   end
endmodule

// File: rtl/tstamp_readout.sv
module tstamp_readout #(
   parameter int unsigned NUM_BUF = 5,
   parameter int unsigned NUM_TX  = 3,
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned IDX_W   = 3
) (
   input  logic [NUM_BUF-1:0][2*BYTE_W-1:0] stamps,
   input  logic [NUM_TX-1:0]                tx_empty,
   input  logic [IDX_W-1:0]                 rd_idx,
   input  logic                             rd_hi,
   output logic [BYTE_W-1:0]                rd_data
);
   localparam int unsigned STAMP_W = 2 * BYTE_W;

   logic [NUM_BUF-1:0] visible;
   logic [STAMP_W-1:0] sel;
   logic               sel_ok;

   for (genvar i = 0; i < NUM_BUF; i++) begin : g_vis
      if (i < NUM_TX) begin : g_tx
         assign visible[i] = tx_empty[i];
      end else begin : g_rx
         assign visible[i] = 1'b1;
      end
   end

   always_comb begin
      sel    = '0;
      sel_ok = 1'b0;
      for (int i = 0; i < NUM_BUF; i++) begin
         if (rd_idx == IDX_W'(i)) begin
            sel    = stamps[i];
            sel_ok = visible[i];
         end
      end
   end

   assign rd_data = !sel_ok ? '0 :
                    rd_hi   ? sel[STAMP_W-1 -: BYTE_W] : sel[BYTE_W-1:0];
endmodule

// File: rtl/can_tstamp_unit.sv
module can_tstamp_unit #(
   parameter int unsigned NUM_BUF = 5,
   parameter int unsigned NUM_TX  = 3,
   parameter int unsigned BYTE_W  = tstamp_pkg::HOST_BYTE_W,
   parameter int unsigned IDX_W   = tstamp_pkg::idx_width(NUM_BUF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              init_mode,
   input  logic              ts_en,
   input  logic              eof_valid,
   input  logic [IDX_W-1:0]  act_idx,
   input  logic [NUM_TX-1:0] tx_empty,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic              rd_hi,
   output logic [BYTE_W-1:0] rd_data
);
   localparam int unsigned STAMP_W = 2 * BYTE_W;

   if (NUM_TX < 1 || NUM_TX > NUM_BUF) begin : g_bad_tx
      $error("NUM_TX must lie in 1..NUM_BUF");
   end
   if ((1 << IDX_W) < NUM_BUF) begin : g_bad_idx
      $error("IDX_W too narrow for NUM_BUF");
   end

   logic [STAMP_W-1:0]              count;
   logic [NUM_BUF-1:0][STAMP_W-1:0] stamps;
   logic                            cap_en;

   assign cap_en = ts_en && eof_valid;

   tstamp_counter #(.CNT_W(STAMP_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
      .init_mode(init_mode), .count(count));

   tstamp_bank #(.NUM_BUF(NUM_BUF), .CNT_W(STAMP_W), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(act_idx),
      .count(count), .stamps(stamps));

   tstamp_readout #(.NUM_BUF(NUM_BUF), .NUM_TX(NUM_TX), .BYTE_W(BYTE_W),
                    .IDX_W(IDX_W)) u_rd (
      .stamps(stamps), .tx_empty(tx_empty), .rd_idx(rd_idx),
      .rd_hi(rd_hi), .rd_data(rd_data));

   always_comb begin
      if (rst_n) begin
         for (int i = 0; i < NUM_TX; i++) begin
            if (rd_idx == IDX_W'(i) && !tx_empty[i])
               assert_tx_hidden_R8: assert (rd_data == '0);
         end
         if (int'(rd_idx) >= NUM_BUF)
            assert_unmapped_read_R9: assert (rd_data == '0);
      end
   end
endmodule

// File: tb/tb_can_tstamp_unit.sv
module tb_can_tstamp_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 5;
   localparam int NT = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0, init_mode = 1'b0, ts_en = 1'b0, eof_valid = 1'b0;
   logic [2:0] act_idx = '0;
   logic [2:0] tx_empty = 3'b111;
   logic [2:0] rd_idx = '0;
   logic       rd_hi = 1'b0;
   logic [7:0] rd_data;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [15:0] mcnt = '0;
   logic [15:0] mst [NB];

   can_tstamp_unit dut (.clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
      .init_mode(init_mode), .ts_en(ts_en), .eof_valid(eof_valid),
      .act_idx(act_idx), .tx_empty(tx_empty), .rd_idx(rd_idx),
      .rd_hi(rd_hi), .rd_data(rd_data));

   always #(CLK_PERIOD/2) clk = ~clk;

   // One clock: inputs were set at the preceding negedge; the model updates at posedge.
   task automatic step(input logic tk, input logic eof, input logic [2:0] idx);
      bit_tick = tk; eof_valid = eof; act_idx = idx;
      @(posedge clk);
      if (ts_en && eof && int'(idx) < NB) mst[idx] = mcnt;
      if (init_mode) mcnt = '0;
      else if (tk) mcnt = mcnt + 16'd1;
      @(negedge clk);
      bit_tick = 1'b0; eof_valid = 1'b0;
   endtask

   task automatic check_byte(input logic [2:0] idx, input logic hi,
                             input logic [7:0] exp, input string req);
      rd_idx = idx; rd_hi = hi;
      #1;
      checks++;
      if (rd_data !== exp) begin
         fails++;
         $display("FAIL %s slot=%0d hi=%0b actual=%02h expected=%02h", req, idx, hi, rd_data, exp);
      end
   endtask

   task automatic check_slot(input logic [2:0] idx, input string req);
      logic [15:0] v;
      bit vis;
      v = (int'(idx) < NB) ? mst[idx] : 16'h0;
      vis = (int'(idx) < NB) && (int'(idx) >= NT || tx_empty[idx]);
      check_byte(idx, 1'b1, vis ? v[15:8] : 8'h00, req);
      check_byte(idx, 1'b0, vis ? v[7:0]  : 8'h00, req);
   endtask

   initial begin
      repeat (int'(CLK_PERIOD) * 15000) #10;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      ts_en = 1'b1;
      // R4: time base zero right after reset
      step(1'b0, 1'b1, 3'd3);
      check_slot(3'd3, "R4");
      // R1, R7: distinct slots, small counts
      for (int b = 0; b < NB; b++) begin
         for (int t = 0; t < 3 + 2*b; t++) step(1'b1, 1'b0, 3'd0);
         step(1'b0, 1'b1, 3'(b));
      end
      for (int b = 0; b < NB; b++) check_slot(3'(b), "R1_R7");
      // R2: idle cycles hold the count
      for (int t = 0; t < 7; t++) step(1'b0, 1'b0, 3'd0);
      step(1'b0, 1'b1, 3'd4);
      check_slot(3'd4, "R2");
      // R6: tick and strobe in the same cycle keep the old value
      step(1'b1, 1'b1, 3'd2);
      check_slot(3'd2, "R6");
      // R5: disabled stamping writes nothing
      for (int t = 0; t < 5; t++) step(1'b1, 1'b0, 3'd0);
      ts_en = 1'b0;
      step(1'b0, 1'b1, 3'd1);
      check_slot(3'd1, "R5");
      ts_en = 1'b1;
      // R9: out-of-range strobes write nothing; out-of-range reads are zero
      for (int k = NB; k < 8; k++) step(1'b1, 1'b1, 3'(k));
      for (int b = 0; b < 8; b++) check_slot(3'(b), "R9");
      // R8: hidden transmit stamps, receive slots untouched
      tx_empty = 3'b000;
      for (int b = 0; b < NB; b++) check_slot(3'(b), "R8");
      tx_empty = 3'b101;
      check_slot(3'd1, "R8");
      check_slot(3'd0, "R8");
      tx_empty = 3'b111;
      // R4: init mode clears the time base, even with ticks
      init_mode = 1'b1;
      step(1'b1, 1'b0, 3'd0);
      step(1'b1, 1'b1, 3'd0);
      check_slot(3'd0, "R4");
      init_mode = 1'b0;
      step(1'b0, 1'b1, 3'd3);
      check_slot(3'd3, "R4");
      // R2, R7: sweep across the range, one stamp per segment
      for (int s = 0; s < 15; s++) begin
         for (int t = 0; t < 4093 + s; t++) step(1'b1, 1'b0, 3'd0);
         step(1'b0, 1'b1, 3'(s % NB));
         check_slot(3'(s % NB), "R2_R7");
      end
      // R3: reach the top value, then wrap
      while (mcnt != 16'hFFFF) step(1'b1, 1'b0, 3'd0);
      step(1'b0, 1'b1, 3'd4);
      check_slot(3'd4, "R3");
      step(1'b1, 1'b1, 3'd3);
      check_slot(3'd3, "R6");
      step(1'b0, 1'b1, 3'd0);
      check_slot(3'd0, "R3");
      step(1'b1, 1'b0, 3'd0);
      step(1'b0, 1'b1, 3'd1);
      check_slot(3'd1, "R3");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule